// File: doc/BRIEF.md
# Interrupt Request Collector with LCD Status Compare

This block sits between the peripheral event sources of a small 8-bit system and its CPU. It latches single-cycle request pulses from the frame-blank, timer, serial and keypad sources into a pending-request register that software can read back and overwrite. It also produces the LCD status read value and raises the status interrupt itself when the current scanline number matches the compare value.

Each cycle the unit masks the pending requests with the enable mask. If the CPU's global interrupt enable is on, the unit picks the single highest-priority survivor and presents a service strobe together with that source's vector address. On the following clock edge it drops the chosen request. The CPU uses the same strobe to clear its global enable and to push its return address. Pushing the stack is not part of this block.

Top module: `irq_stat_unit`

## Requirements
- R1: The pending-request read value `flagRdData` has frame-blank at bit 0, status at bit 1, timer at bit 2, serial at bit 3 and keypad at bit 4. Bits 7 to 5 always read 1.
- R2: A one-cycle pulse on a source request input sets its pending bit, visible from the next cycle. The bit stays set until that source is serviced or software overwrites it.
- R3: When `flagWrEn` is high, pending bits 4..0 take `flagWrData[4:0]` at the clock edge. A request pulse in the same cycle still sets its bit.
- R4: The status request (bit 1) is set when the condition "`lineCount` equals `lineCompare` and `statStored` bit 6 is 1" becomes true. It is not raised while bit 6 is 0, and it is not raised again while the condition stays true.
- R5: `statRdData` equals `statStored[7:3]` in bits 7..3, 1 in bit 2 exactly when `lineCount` equals `lineCompare`, and 0 in bits 1..0.
- R6: `serviceStrobe` and `masterEnClear` are high in a cycle only when `masterEn` is 1 and at least one pending bit has its `enableMask` bit set. Both are combinational in that cycle.
- R7: Among the enabled pending sources the lowest bit index wins. The order is frame-blank, status, timer, serial, keypad. `vectorAddr` is 0x40, 0x48, 0x50, 0x58 or 0x60 respectively.
- R8: Only the serviced source's pending bit clears at the next edge. Lower-priority requests stay pending and are serviced in later cycles.
- R9: After reset no request is pending, `flagRdData` reads 0xE0 and no strobe is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| vblankReq | input | 1 | Frame-blank request pulse |
| timerReq | input | 1 | Timer request pulse |
| serialReq | input | 1 | Serial request pulse |
| joypadReq | input | 1 | Keypad request pulse |
| flagWrEn | input | 1 | Write strobe for the pending-request register |
| flagWrData | input | 8 | Data written to the pending-request register |
| enableMask | input | 8 | Per-source enable mask, same bit layout as the pending register |
| masterEn | input | 1 | CPU global interrupt enable |
| lineCount | input | 8 | Current scanline number |
| lineCompare | input | 8 | Scanline compare value |
| statStored | input | 8 | Software-written LCD status value |
| flagRdData | output | 8 | Pending-request read value |
| statRdData | output | 8 | LCD status read value |
| serviceStrobe | output | 1 | A source is being serviced this cycle |
| masterEnClear | output | 1 | Tells the CPU to drop its global enable |
| vectorAddr | output | 16 | Vector of the serviced source |

## Verification
The bound checker checks these properties on every cycle:
- the constant high bits of the pending read value;
- the status read value's compare bit against the live line numbers;
- that a strobe only appears with the global enable on;
- that vectors stay inside the table and are aligned;
- that a pulse always appears in the next cycle;
- that a serviced frame-blank request is gone a cycle later.

Only the directed scenarios show the rest:
- the full priority walk through all five sources;
- the edge-only nature of the status request;
- write-versus-pulse ordering;
- that a masked or globally disabled request stays pending untouched.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int NUM_SRC  = 5;
  localparam int REG_W    = 8;
  localparam int IDX_VBL  = 0;
  localparam int IDX_STAT = 1;
  localparam int IDX_TMR  = 2;
  localparam int IDX_SER  = 3;
  localparam int IDX_JOY  = 4;

  typedef struct packed {
    logic               take;
    logic [NUM_SRC-1:0] clearMask;
  } svcCmd_t;
endpackage

// File: rtl/irq_datapath.sv
module irq_datapath
  import irq_pkg::*;
#(
  parameter int LINE_W      = 8,
  parameter int STAT_EN_BIT = 6
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcPulse,
  input  logic               flagWrEn,
  input  logic [NUM_SRC-1:0] flagWrData,
  input  logic [LINE_W-1:0]  lineCount,
  input  logic [LINE_W-1:0]  lineCompare,
  input  logic [REG_W-1:0]   statStored,
  input  svcCmd_t            cmd,
  output logic [NUM_SRC-1:0] flags,
  output logic [REG_W-1:0]   statRd
);
  logic               lineEq;
  logic               statCond;
  logic               statCondPrev;
  logic [NUM_SRC-1:0] allPulse;
  logic [NUM_SRC-1:0] flagsNext;

  assign lineEq   = (lineCount == lineCompare);
  assign statCond = lineEq && statStored[STAT_EN_BIT];
  assign statRd   = {statStored[REG_W-1:3], lineEq, 2'b00};

  // status request fires on the rising edge of the compare condition
  always_comb begin
    allPulse           = srcPulse;
    allPulse[IDX_STAT] = srcPulse[IDX_STAT] | (statCond & ~statCondPrev);
  end

  // order: software write, then service clear, then new requests
  always_comb begin
    flagsNext = flags;
    if (flagWrEn) flagsNext = flagWrData;
    if (cmd.take) flagsNext = flagsNext & ~cmd.clearMask;
    flagsNext = flagsNext | allPulse;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      flags        <= '0;
      statCondPrev <= 1'b0;
    end else begin
      flags        <= flagsNext;
      statCondPrev <= statCond;
    end
  end
endmodule

// File: rtl/irq_control.sv
module irq_control
  import irq_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int VEC_BASE = 'h40,
  parameter int VEC_STEP = 8
) (
  input  logic [NUM_SRC-1:0] flags,
  input  logic [NUM_SRC-1:0] enableMask,
  input  logic               masterEn,
  output svcCmd_t            cmd,
  output logic [ADDR_W-1:0]  vectorAddr
);
  localparam int IDX_W = $clog2(NUM_SRC);

  logic [NUM_SRC-1:0] live;
  logic [IDX_W-1:0]   winIdx;

  assign live = flags & enableMask;

  // scan from top down so the lowest index wins
  always_comb begin
    winIdx = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (live[i]) winIdx = IDX_W'(i);
    end
  end

  always_comb begin
    cmd.take      = masterEn && (live != '0);
    cmd.clearMask = '0;
    if (cmd.take) cmd.clearMask[winIdx] = 1'b1;
    vectorAddr = ADDR_W'(VEC_BASE) + ADDR_W'(winIdx) * ADDR_W'(VEC_STEP);
  end
endmodule

// File: rtl/irq_stat_unit.sv
module irq_stat_unit
  import irq_pkg::*;
#(
  parameter int LINE_W = 8,
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              vblankReq,
  input  logic              timerReq,
  input  logic              serialReq,
  input  logic              joypadReq,
  input  logic              flagWrEn,
  input  logic [REG_W-1:0]  flagWrData,
  input  logic [REG_W-1:0]  enableMask,
  input  logic              masterEn,
  input  logic [LINE_W-1:0] lineCount,
  input  logic [LINE_W-1:0] lineCompare,
  input  logic [REG_W-1:0]  statStored,
  output logic [REG_W-1:0]  flagRdData,
  output logic [REG_W-1:0]  statRdData,
  output logic              serviceStrobe,
  output logic              masterEnClear,
  output logic [ADDR_W-1:0] vectorAddr
);
  localparam int PAD_W = REG_W - NUM_SRC;

  svcCmd_t            cmd;
  logic [NUM_SRC-1:0] flags;
  logic [NUM_SRC-1:0] srcPulse;

  always_comb begin
    srcPulse           = '0;
    srcPulse[IDX_VBL]  = vblankReq;
    srcPulse[IDX_TMR]  = timerReq;
    srcPulse[IDX_SER]  = serialReq;
    srcPulse[IDX_JOY]  = joypadReq;
  end

  irq_datapath #(.LINE_W(LINE_W)) u_dp (
    .clk(clk), .rstN(rstN), .srcPulse(srcPulse),
    .flagWrEn(flagWrEn), .flagWrData(flagWrData[NUM_SRC-1:0]),
    .lineCount(lineCount), .lineCompare(lineCompare),
    .statStored(statStored), .cmd(cmd), .flags(flags), .statRd(statRdData)
  );

  irq_control #(.ADDR_W(ADDR_W)) u_ctl (
    .flags(flags), .enableMask(enableMask[NUM_SRC-1:0]),
    .masterEn(masterEn), .cmd(cmd), .vectorAddr(vectorAddr)
  );

  assign flagRdData    = {{PAD_W{1'b1}}, flags};
  assign serviceStrobe = cmd.take;
  assign masterEnClear = cmd.take;
endmodule

// File: rtl/irq_stat_unit_chk.sv
module irq_stat_unit_chk #(
  parameter int LINE_W = 8,
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              vblankReq,
  input logic              flagWrEn,
  input logic              masterEn,
  input logic [LINE_W-1:0] lineCount,
  input logic [LINE_W-1:0] lineCompare,
  input logic [7:0]        flagRdData,
  input logic [7:0]        statRdData,
  input logic              serviceStrobe,
  input logic [ADDR_W-1:0] vectorAddr
);
  // R1
  pad_ones_chk: assert property (@(posedge clk) disable iff (!rstN)
    flagRdData[7:5] == 3'b111);

  // R5
  stat_eq_chk: assert property (@(posedge clk) disable iff (!rstN)
    (statRdData[2] == (lineCount == lineCompare)) && (statRdData[1:0] == 2'b00));

  // R6
  strobe_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    serviceStrobe |-> masterEn);

  // R7
  vector_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    serviceStrobe |-> (vectorAddr[2:0] == 3'b000 && vectorAddr >= 16'h40 && vectorAddr <= 16'h60));

  // R2
  pulse_lands_chk: assert property (@(posedge clk) disable iff (!rstN)
    vblankReq |=> flagRdData[0]);

  // R8
  vbl_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (serviceStrobe && vectorAddr == 16'h40 && !vblankReq && !flagWrEn) |=> !flagRdData[0]);
endmodule

bind irq_stat_unit irq_stat_unit_chk #(.LINE_W(LINE_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .vblankReq(vblankReq), .flagWrEn(flagWrEn),
  .masterEn(masterEn), .lineCount(lineCount), .lineCompare(lineCompare),
  .flagRdData(flagRdData), .statRdData(statRdData),
  .serviceStrobe(serviceStrobe), .vectorAddr(vectorAddr)
);

// File: tb/test_irq_stat_unit.sv
`timescale 1ns/1ps
module test_irq_stat_unit;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        vblankReq = 0, timerReq = 0, serialReq = 0, joypadReq = 0;
  logic        flagWrEn = 0;
  logic [7:0]  flagWrData = 0, enableMask = 0;
  logic        masterEn = 0;
  logic [7:0]  lineCount = 0, lineCompare = 0, statStored = 0;
  logic [7:0]  flagRdData, statRdData;
  logic        serviceStrobe, masterEnClear;
  logic [15:0] vectorAddr;
  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  irq_stat_unit i_irq_stat_unit (
    .clk(clk), .rstN(rstN), .vblankReq(vblankReq), .timerReq(timerReq),
    .serialReq(serialReq), .joypadReq(joypadReq), .flagWrEn(flagWrEn),
    .flagWrData(flagWrData), .enableMask(enableMask), .masterEn(masterEn),
    .lineCount(lineCount), .lineCompare(lineCompare), .statStored(statStored),
    .flagRdData(flagRdData), .statRdData(statRdData),
    .serviceStrobe(serviceStrobe), .masterEnClear(masterEnClear),
    .vectorAddr(vectorAddr)
  );

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // step to next falling edge, then let combinational outputs settle
  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic clearAll();
    vblankReq = 0; timerReq = 0; serialReq = 0; joypadReq = 0;
    flagWrEn = 1; flagWrData = 8'h00; masterEn = 0; enableMask = 0;
    step();
    flagWrEn = 0;
    #1;
  endtask

  task automatic testReset();
    chk("R9 flag read after reset", flagRdData, 8'hE0);
    chk("R9 no strobe after reset", serviceStrobe, 1'b0);
  endtask

  task automatic testLayout();
    clearAll();
    vblankReq = 1; step(); vblankReq = 0; #1;
    chk("R1 R2 vblank at bit0", flagRdData, 8'hE1);
    step();
    chk("R2 bit holds", flagRdData, 8'hE1);
    timerReq = 1; step(); timerReq = 0; #1;
    chk("R1 timer at bit2", flagRdData, 8'hE5);
    serialReq = 1; step(); serialReq = 0; #1;
    chk("R1 serial at bit3", flagRdData, 8'hED);
    joypadReq = 1; step(); joypadReq = 0; #1;
    chk("R1 joypad at bit4", flagRdData, 8'hFD);
  endtask

  task automatic testWrite();
    clearAll();
    flagWrEn = 1; flagWrData = 8'h0A; step(); flagWrEn = 0; #1;
    chk("R3 write sets bits", flagRdData, 8'hEA);
    flagWrEn = 1; flagWrData = 8'h00; timerReq = 1; step();
    flagWrEn = 0; timerReq = 0; #1;
    chk("R3 pulse wins over write", flagRdData, 8'hE4);
  endtask

  task automatic testStatRead();
    statStored = 8'hFF; lineCount = 8'd7; lineCompare = 8'd9; #1;
    chk("R5 stat no match", statRdData, 8'hF8);
    lineCompare = 8'd7; #1;
    chk("R5 stat match", statRdData, 8'hFC);
    statStored = 8'h03; #1;
    chk("R5 low bits cleared", statRdData, 8'h04);
  endtask

  task automatic testStatIrq();
    statStored = 8'h00; lineCount = 8'd3; lineCompare = 8'd5;
    clearAll();
    lineCompare = 8'd3; step();
    chk("R4 no request without enable bit", flagRdData, 8'hE0);
    lineCompare = 8'd5; step();
    statStored = 8'h40; lineCompare = 8'd3; step();
    chk("R4 request on match", flagRdData, 8'hE2);
    flagWrEn = 1; flagWrData = 8'h00; step(); flagWrEn = 0; #1;
    step();
    chk("R4 no repeat while match held", flagRdData, 8'hE0);
    lineCompare = 8'd4; step();
    lineCompare = 8'd3; step();
    chk("R4 new match raises again", flagRdData, 8'hE2);
    statStored = 8'h00;
  endtask

  task automatic testPriority();
    clearAll();
    flagWrEn = 1; flagWrData = 8'h1F; step(); flagWrEn = 0;
    enableMask = 8'h1F; masterEn = 1; #1;
    chk("R6 strobe when enabled", serviceStrobe, 1'b1);
    chk("R6 master clear", masterEnClear, 1'b1);
    chk("R7 vblank vector", vectorAddr, 16'h0040);
    step();
    chk("R8 only vblank cleared", flagRdData, 8'hFE);
    chk("R7 stat vector", vectorAddr, 16'h0048);
    step();
    chk("R7 timer vector", vectorAddr, 16'h0050);
    step();
    chk("R7 serial vector", vectorAddr, 16'h0058);
    step();
    chk("R7 joypad vector", vectorAddr, 16'h0060);
    step();
    chk("R8 all drained", flagRdData, 8'hE0);
    chk("R6 idle when none pending", serviceStrobe, 1'b0);
    masterEn = 0;
  endtask

  task automatic testGating();
    clearAll();
    flagWrEn = 1; flagWrData = 8'h04; step(); flagWrEn = 0;
    enableMask = 8'h03; masterEn = 1; #1;
    chk("R6 masked source ignored", serviceStrobe, 1'b0);
    step();
    chk("R6 masked stays pending", flagRdData, 8'hE4);
    enableMask = 8'h04; masterEn = 0; #1;
    chk("R6 no strobe with master off", masterEnClear, 1'b0);
    step();
    chk("R6 pending kept with master off", flagRdData, 8'hE4);
  endtask

  initial begin
    fork
      begin
        step(); step();
        rstN = 1;
        step();
        testReset();
        testLayout();
        testWrite();
        testStatRead();
        testStatIrq();
        testPriority();
        testGating();
      end
      begin
        repeat (5000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule